// File: doc/BRIEF.md
# Policy-Driven Clock Enable Controller

This block drives one enable line per clock in a group. Each line follows a mask chosen by the power policy that is currently active. Software programs one mask word per policy through a simple register bus. Clock `i` always owns bit `i` of every mask word. While the controller's engine is running, it samples a policy-select input and drives the registered enables from the mask of that policy.

To reprogram the masks, software first unlocks the register file with a key. It then halts the engine and rewrites the masks. Finally it restarts the engine with a go command that names one of two restart modes. While the engine is halted, the enables are frozen. A short busy window marks the hand-over back to running. Writes made in the wrong state are discarded, and a dropped mask write leaves a sticky error flag.

Top module: `polclk_ctrl`

## Requirements
- R1: After reset, every enable is 1 and the engine is running. Write access is closed (register 0 reads 0), the error flag and busy flag are 0, and the control register reads 0.
- R2: A write to register 0 with key 0xC3A5E1 in bits 31:8 sets write access to the value of bit 0. A write with any other key closes write access. Register 0 reads back the access state in bit 0 and never returns the key.
- R3: While write access is closed, writes to registers 1 to 7 have no effect.
- R4: Writing 1 to bit 0 of register 2 halts the engine. Register 2 bit 0 reads 1 while halted. While the engine is halted or loading, the enables and the reported active policy hold their values, whatever the policy-select input does.
- R5: Registers 4 to 7 hold the masks of policies 0 to 3, with clock `i` at bit `i`. Bits at or above the clock count are neither stored nor read back (they read 0). A mask write is stored only while the engine is halted.
- R6: A mask write that reaches the controller while the engine is not halted is dropped. It sets the sticky error flag, which is bit 0 of register 3. Writing 1 to that bit clears the flag.
- R7: A write to register 1 with bit 0 (go) set and at least one of bit 1 or bit 2 (restart modes) set restarts a halted engine. Go without a mode bit is ignored. Busy, which is register 1 bit 0, reads 1 for the first two cycles after the accepted write. In the third cycle busy reads 0 and the enables show the new mask of the selected policy.
- R8: While the engine is running, the enables equal the mask of the policy selected on the previous cycle. Register 3 shows running in bit 1 and the active policy in bits 5:4.
- R9: A go write while the engine is running is ignored: busy stays 0 and the recorded mode is unchanged.
- R10: Register 1 bits 2:1 read back the mode bits of the last accepted go write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Register word address, shared by read and write |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| polSel | input | POL_W | Active policy request |
| clkEn | output | NUM_CLK | Registered per-clock enables |

## Verification
The bench builds the controller with twelve clocks and four policies. With twelve clocks, each 32-bit mask word has twenty spare bits. Writing ones into them and reading back zeros exercises the truncation on the storage path, which the full-width default would hide. With four policies, each mask can be selected in turn, so a wrong index or a stale selection shows up as a distinct enable pattern.

// File: rtl/polclk_pkg.sv
package polclk_pkg;

  // register word addresses (masks follow in policy order)
  localparam int REG_ACCESS = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_UPD    = 2;
  localparam int REG_STAT   = 3;
  localparam int REG_MASK0  = 4;

  typedef enum logic [1:0] {
    ENG_RUN  = 2'd0,
    ENG_HALT = 2'd1,
    ENG_LOAD = 2'd2
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic maskWe;
    logic track;
  } dpStrobe_t;

  // control state shown to the datapath readback
  typedef struct packed {
    logic       wrOpen;
    logic       busy;
    logic       running;
    logic       halted;
    logic       err;
    logic [1:0] mode;
  } ctlStat_t;

endpackage

// File: rtl/polclk_ctl.sv
module polclk_ctl
  import polclk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NUM_POL = 4,
  parameter int KEY_W = 24,
  parameter logic [KEY_W-1:0] ACCESS_KEY = 24'hC3A5E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [2:0]        wrCmd,
  output dpStrobe_t         strobe,
  output ctlStat_t          stat
);

  localparam logic [ADDR_W-1:0] A_ACCESS = ADDR_W'(REG_ACCESS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_UPD    = ADDR_W'(REG_UPD);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] A_MASKLO = ADDR_W'(REG_MASK0);
  localparam logic [ADDR_W-1:0] A_MASKHI = ADDR_W'(REG_MASK0 + NUM_POL - 1);

  engState_t  engState, engNext;
  logic       wrOpen, busyQ, errQ;
  logic [1:0] modeQ;

  logic accessHit, allowed, maskHit, haltHit, goHit, errClr, maskDrop;

  always_comb begin
    accessHit = busWe && (busAddr == A_ACCESS);
    allowed   = busWe && wrOpen && (busAddr != A_ACCESS);
    maskHit   = allowed && (busAddr >= A_MASKLO) && (busAddr <= A_MASKHI);
    haltHit   = allowed && (busAddr == A_UPD) && wrCmd[0];
    goHit     = allowed && (busAddr == A_CTRL) && wrCmd[0] && (|wrCmd[2:1])
                && (engState == ENG_HALT);
    errClr    = allowed && (busAddr == A_STAT) && wrCmd[0];
    maskDrop  = maskHit && (engState != ENG_HALT);
  end

  always_comb begin
    engNext = engState;
    if (haltHit) begin
      engNext = ENG_HALT;
    end else begin
      unique case (engState)
        ENG_RUN:  engNext = ENG_RUN;
        ENG_HALT: engNext = goHit ? ENG_LOAD : ENG_HALT;
        ENG_LOAD: engNext = ENG_RUN;
        default:  engNext = ENG_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engState <= ENG_RUN;
      wrOpen   <= 1'b0;
      busyQ    <= 1'b0;
      errQ     <= 1'b0;
      modeQ    <= 2'b00;
    end else begin
      engState <= engNext;
      if (accessHit) wrOpen <= (wrKey == ACCESS_KEY) && wrCmd[0];
      if (haltHit) busyQ <= 1'b0;
      else if (goHit) busyQ <= 1'b1;
      else if (engState == ENG_RUN && busyQ) busyQ <= 1'b0;
      if (goHit) modeQ <= wrCmd[2:1];
      if (maskDrop) errQ <= 1'b1;
      else if (errClr) errQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.maskWe = maskHit && (engState == ENG_HALT);
    strobe.track  = (engState == ENG_RUN);
    stat.wrOpen   = wrOpen;
    stat.busy     = busyQ;
    stat.running  = (engState == ENG_RUN);
    stat.halted   = (engState == ENG_HALT);
    stat.err      = errQ;
    stat.mode     = modeQ;
  end

endmodule

// File: rtl/polclk_dp.sv
module polclk_dp
  import polclk_pkg::*;
#(
  parameter int NUM_CLK = 32,
  parameter int NUM_POL = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int POL_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  ctlStat_t                   stat,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [NUM_CLK-1:0]         wrMask,
  input  logic [POL_W-1:0]           polSel,
  output logic [NUM_CLK-1:0]         clkEn,
  output logic [POL_W-1:0]           actPol,
  output logic [DATA_W-1:0]          busRdata,
  output logic [NUM_POL*NUM_CLK-1:0] maskFlat
);

  logic [NUM_CLK-1:0] maskQ [NUM_POL];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_POL; p++) maskQ[p] <= '1;
    end else if (strobe.maskWe) begin
      for (int p = 0; p < NUM_POL; p++)
        if (busAddr == ADDR_W'(REG_MASK0 + p)) maskQ[p] <= wrMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEn  <= '1;
      actPol <= '0;
    end else if (strobe.track) begin
      clkEn  <= maskQ[polSel];
      actPol <= polSel;
    end
  end

  for (genvar p = 0; p < NUM_POL; p++) begin : g_flat
    assign maskFlat[p*NUM_CLK +: NUM_CLK] = maskQ[p];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(REG_ACCESS)) begin
      busRdata[0] = stat.wrOpen;
    end else if (busAddr == ADDR_W'(REG_CTRL)) begin
      busRdata[0]   = stat.busy;
      busRdata[2:1] = stat.mode;
    end else if (busAddr == ADDR_W'(REG_UPD)) begin
      busRdata[0] = stat.halted;
    end else if (busAddr == ADDR_W'(REG_STAT)) begin
      busRdata[0]         = stat.err;
      busRdata[1]         = stat.running;
      busRdata[4 +: POL_W] = actPol;
    end else begin
      for (int p = 0; p < NUM_POL; p++)
        if (busAddr == ADDR_W'(REG_MASK0 + p)) busRdata = DATA_W'(maskQ[p]);
    end
  end

endmodule

// File: rtl/polclk_ctrl.sv
module polclk_ctrl
  import polclk_pkg::*;
#(
  parameter int NUM_CLK = 32,
  parameter int NUM_POL = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int KEY_W = 24,
  parameter logic [KEY_W-1:0] ACCESS_KEY = 24'hC3A5E1,
  localparam int POL_W = (NUM_POL > 1) ? $clog2(NUM_POL) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [POL_W-1:0]  polSel,
  output logic [NUM_CLK-1:0] clkEn
);

  dpStrobe_t                  strobe;
  ctlStat_t                   stat;
  logic [POL_W-1:0]           actPol;
  logic [NUM_POL*NUM_CLK-1:0] maskFlat;

  polclk_ctl #(
    .ADDR_W(ADDR_W), .NUM_POL(NUM_POL), .KEY_W(KEY_W), .ACCESS_KEY(ACCESS_KEY)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .wrKey(busWdata[DATA_W-1 -: KEY_W]), .wrCmd(busWdata[2:0]),
    .strobe(strobe), .stat(stat)
  );

  polclk_dp #(
    .NUM_CLK(NUM_CLK), .NUM_POL(NUM_POL), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .POL_W(POL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stat(stat),
    .busAddr(busAddr), .wrMask(busWdata[NUM_CLK-1:0]), .polSel(polSel),
    .clkEn(clkEn), .actPol(actPol), .busRdata(busRdata), .maskFlat(maskFlat)
  );

endmodule

// File: rtl/polclk_chk.sv
module polclk_chk
  import polclk_pkg::*;
#(
  parameter int NUM_CLK = 32,
  parameter int NUM_POL = 4,
  parameter int ADDR_W = 4,
  parameter int KEY_W = 24,
  parameter logic [KEY_W-1:0] ACCESS_KEY = 24'hC3A5E1,
  parameter int POL_W = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [KEY_W-1:0]           wrKey,
  input logic [2:0]                 wrCmd,
  input logic [POL_W-1:0]           polSel,
  input logic [NUM_CLK-1:0]         clkEn,
  input ctlStat_t                   stat,
  input logic [NUM_POL*NUM_CLK-1:0] maskFlat
);

  logic [NUM_CLK-1:0] pickMask;
  logic               maskAddr;

  always_comb begin
    pickMask = maskFlat[polSel*NUM_CLK +: NUM_CLK];
    maskAddr = (busAddr >= ADDR_W'(REG_MASK0)) &&
               (busAddr <= ADDR_W'(REG_MASK0 + NUM_POL - 1));
  end

  // R2: a wrong key always closes access
  a_r2_bad_key_closes: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(REG_ACCESS) && wrKey != ACCESS_KEY) |=> !stat.wrOpen);

  // R3: locked writes cannot stop a running engine
  a_r3_locked_keeps_run: assert property (@(posedge clk) disable iff (!rstN)
    (!stat.wrOpen && busWe && busAddr != ADDR_W'(REG_ACCESS) && stat.running)
    |=> stat.running);

  // R4: enables frozen while halted
  a_r4_halt_freezes: assert property (@(posedge clk) disable iff (!rstN)
    stat.halted |=> $stable(clkEn));

  // R6: dropped mask write flags an error
  a_r6_drop_sets_err: assert property (@(posedge clk) disable iff (!rstN)
    (stat.wrOpen && busWe && maskAddr && !stat.halted) |=> stat.err);

  // R7: go without a mode bit leaves the engine halted
  a_r7_go_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    (stat.halted && stat.wrOpen && busWe && busAddr == ADDR_W'(REG_CTRL) &&
     wrCmd == 3'b001) |=> stat.halted);

  // R7: accepted go raises busy before running
  a_r7_go_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stat.halted && stat.wrOpen && busWe && busAddr == ADDR_W'(REG_CTRL) &&
     wrCmd[0] && (|wrCmd[2:1])) |=> (stat.busy && !stat.running));

  // R8: running enables follow the selected mask
  a_r8_tracks_mask: assert property (@(posedge clk) disable iff (!rstN)
    stat.running |=> clkEn == $past(pickMask));

  // R9: go while running never raises busy
  a_r9_go_running_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stat.running && busWe && busAddr == ADDR_W'(REG_CTRL)) |=> !stat.busy);

endmodule

bind polclk_ctrl polclk_chk #(
  .NUM_CLK(NUM_CLK), .NUM_POL(NUM_POL), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
  .ACCESS_KEY(ACCESS_KEY), .POL_W(POL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .wrKey(busWdata[DATA_W-1 -: KEY_W]), .wrCmd(busWdata[2:0]),
  .polSel(polSel), .clkEn(clkEn), .stat(stat), .maskFlat(maskFlat)
);

// File: tb/polclk_ctrl_tb.sv
module polclk_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCLK = 12;
  localparam int NPOL = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [23:0] KEY = 24'hC3A5E1;
  localparam logic [31:0] ALL = 32'h0000_0FFF;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busWe = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic [DW-1:0]   busWdata = '0;
  logic [DW-1:0]   busRdata;
  logic [1:0]      polSel = 2'd0;
  logic [NCLK-1:0] clkEn;

  polclk_ctrl #(.NUM_CLK(NCLK), .NUM_POL(NPOL), .ADDR_W(AW), .DATA_W(DW),
                .ACCESS_KEY(KEY)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .polSel(polSel), .clkEn(clkEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       tag;
    bit          isReg;
    logic [31:0] exp;
  } item_t;

  item_t sbq[$];
  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations mid-cycle
  always @(negedge clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = it.isReg ? busRdata : 32'(clkEn);
      nChk++;
      if (act !== it.exp) begin
        nFail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      nFail++;
      $display("FAIL R1 watchdog actual=%0d expected<5000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic chkEn(input string tag, input logic [31:0] e);
    item_t it;
    it.tag = tag; it.isReg = 1'b0; it.exp = e;
    sbq.push_back(it);
  endtask

  task automatic chkReg(input string tag, input logic [AW-1:0] a, input logic [31:0] e);
    item_t it;
    busAddr = a;
    it.tag = tag; it.isReg = 1'b1; it.exp = e;
    sbq.push_back(it);
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chkEn("R1 enables", ALL);
    chkReg("R1 access", 4'd0, 32'h0);
    chkReg("R1 status", 4'd3, 32'h2);
    chkReg("R1 ctrl", 4'd1, 32'h0);

    // R3 locked writes ignored
    wr(4'd2, 32'h1);
    chkReg("R3 halt ignored", 4'd3, 32'h2);
    wr(4'd4, 32'h0);
    chkReg("R3 mask kept", 4'd4, ALL);

    // R2 access key
    wr(4'd0, {KEY, 8'h01});
    chkReg("R2 open", 4'd0, 32'h1);
    wr(4'd0, {24'h123456, 8'h01});
    chkReg("R2 bad key closes", 4'd0, 32'h0);
    wr(4'd0, {KEY, 8'h01});

    // R6 mask write while running
    wr(4'd5, 32'h0F0);
    chkReg("R6 mask dropped", 4'd5, ALL);
    chkReg("R6 err set", 4'd3, 32'h3);
    wr(4'd3, 32'h1);
    chkReg("R6 err cleared", 4'd3, 32'h2);

    // R4 halt freezes
    wr(4'd2, 32'h1);
    chkReg("R4 halted", 4'd2, 32'h1);
    chkReg("R4 status", 4'd3, 32'h0);
    polSel = 2'd2;
    tick();
    chkEn("R4 frozen", ALL);
    chkReg("R4 policy held", 4'd3, 32'h0);

    // R5 mask programming
    wr(4'd4, 32'hFFFF_F0A5);
    wr(4'd5, 32'h0000_05A3);
    wr(4'd6, 32'h0000_000F);
    wr(4'd7, 32'h0000_0C30);
    chkReg("R5 mask0 truncated", 4'd4, 32'h0A5);
    chkReg("R5 mask1", 4'd5, 32'h5A3);
    chkReg("R5 mask2", 4'd6, 32'h00F);
    chkReg("R5 mask3", 4'd7, 32'hC30);
    chkEn("R4 still frozen", ALL);

    // R7 go without mode ignored
    wr(4'd1, 32'h1);
    chkReg("R7 go alone stays halted", 4'd2, 32'h1);
    chkReg("R7 go alone no busy", 4'd1, 32'h0);

    // R7 go with first mode bit
    wr(4'd1, 32'h3);
    chkEn("R7 old enables c1", ALL);
    chkReg("R7 busy c1", 4'd1, 32'h3);
    chkEn("R7 old enables c2", ALL);
    chkReg("R7 busy c2", 4'd1, 32'h3);
    chkEn("R7 new enables", 32'h00F);
    chkReg("R10 mode readback", 4'd1, 32'h2);
    chkReg("R8 status policy 2", 4'd3, 32'h22);

    // R8 policy tracking
    polSel = 2'd1;
    tick();
    chkEn("R8 policy 1", 32'h5A3);
    polSel = 2'd3;
    tick();
    chkEn("R8 policy 3", 32'hC30);
    chkReg("R8 status policy 3", 4'd3, 32'h32);
    polSel = 2'd0;
    tick();
    chkEn("R8 policy 0", 32'h0A5);

    // R9 go while running
    wr(4'd1, 32'h5);
    chkReg("R9 no busy keeps mode", 4'd1, 32'h2);
    chkReg("R9 still running", 4'd3, 32'h2);

    // R10 second mode bit
    wr(4'd2, 32'h1);
    wr(4'd1, 32'h5);
    chkReg("R10 busy mode c1", 4'd1, 32'h5);
    chkReg("R10 busy mode c2", 4'd1, 32'h5);
    chkReg("R10 mode after", 4'd1, 32'h4);

    // R2 close with bit 0 clear, R3 locked again
    wr(4'd0, {KEY, 8'h00});
    chkReg("R2 closed by enable bit", 4'd0, 32'h0);
    wr(4'd2, 32'h1);
    chkReg("R3 locked halt ignored", 4'd3, 32'h2);

    repeat (2) tick();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule